// File: doc/BRIEF.md
# SRAM-backed programmable sequence counter

This block is a counter whose successive output values are not arithmetic. They are a list of arbitrary 8-bit values that the user loads beforehand. The list lives in an external asynchronous SRAM with a 16-bit word and an 18-bit address. The block contains its own read and write controller for that SRAM, built from plain logic with no memory IP.

While the program-mode input is high, each accepted byte entry is stored at the next free slot and the sequence length grows by one. The list holds at most 255 entries. With program mode low, a run command restarts the list at its first entry. After that, every 1 Hz enable tick fetches the next stored value and puts it on the output. Past the last entry the list wraps to the start.

Reset is asynchronous and active-high. It clears the output to 0x00 and erases the list by setting the length to zero. The SRAM contents themselves are left as they are. A list of length zero keeps the output at 0x00. Byte entries are assumed to be already decoded; any keypad scanning happens outside the block.

Top module: `seqram_counter`

## Requirements
- R1: While `rst` is high, and from the moment it rises without waiting for a clock edge, `count_out` is 0x00 and the length is zero. All three SRAM strobes (`sram_ce_n`, `sram_oe_n`, `sram_we_n`) are high (inactive).
- R2: An entry is accepted when `prog_mode`=1, `entry_valid`=1 and `busy`=0. The entry is written to SRAM word address equal to the current length. Bits [7:0] of the word carry `entry_byte` and bits [15:8] are 0x00. The length then increases by exactly one.
- R3: Whenever `sram_ce_n` is low, `sram_addr[17:8]` is zero, so only words 0x00..0xFF are ever touched.
- R4: A write cycle follows this order:
  - Address and data are driven, with `sram_dq_oe`=1 and `sram_ce_n` low.
  - `sram_we_n` is then held low for at least WE_CYC (at least 2) clocks.
  - After `sram_we_n` rises, the data stays driven for one more clock.
  - `sram_oe_n` stays high for the whole cycle.
- R5: A read cycle holds `sram_oe_n` and `sram_ce_n` low for RD_WAIT clocks, with `sram_dq_oe`=0. It then loads `sram_rdata[7:0]` into `count_out`. Bits [15:8] of the read word have no effect.
- R6: A `run_go` pulse with `prog_mode`=0 and `busy`=0 resets the read index to 0. When the length is nonzero, `count_out` then becomes entry 0.
- R7: After a run command, each `tick` with `prog_mode`=0 and `busy`=0 moves `count_out` to the next stored entry. The entry after the last one (index length-1) is entry 0.
- R8: With length zero, `count_out` stays 0x00 through run commands and ticks.
- R9: The length never exceeds 255. Entries offered at length 255 cause no SRAM write and leave the length unchanged.
- R10: The following inputs are ignored and leave `count_out` unchanged:
  - ticks while `prog_mode`=1;
  - ticks before the first run command;
  - byte entries while `prog_mode`=0.
- R11: Raising `prog_mode` keeps the stored list and appends further entries after it. Once back in run mode, ticks stay ignored until the next `run_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset; erases the list |
| prog_mode | input | 1 | 1 = program (append) mode, 0 = run mode |
| entry_valid | input | 1 | One-cycle strobe offering `entry_byte` |
| entry_byte | input | 8 | Decoded value to append |
| run_go | input | 1 | Restart replay at entry 0 |
| tick | input | 1 | 1 Hz enable pulse that advances replay |
| count_out | output | 8 | Current counter value |
| busy | output | 1 | SRAM cycle in progress; inputs ignored |
| sram_addr | output | 18 | SRAM word address |
| sram_wdata | output | 16 | Data driven toward the SRAM data pins |
| sram_dq_oe | output | 1 | Enables the pad drivers for `sram_wdata` |
| sram_rdata | input | 16 | Data read from the SRAM data pins |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench goes after the wrap point at both ends of the length range:
- A one-entry list must repeat its single value.
- A full 255-entry list must come back to entry 0 after index 254 rather than reading a 256th word.
- A design that compared against the wrong bound would show a stale or extra value at the wrap.

It offers entries past the capacity limit. A design that let the length roll over to zero would both write SRAM and lose the list.

It also covers a reset pulse in the middle of replay, and an empty list that still receives run commands and ticks. A design that only erased the index, or that read SRAM while empty, would put a non-zero value on the output.

A behavioural SRAM model returns an upper byte that differs from the low byte, so latching the wrong half is visible. The same model times every write-enable pulse and checks that data stays driven past its rising edge.

// File: rtl/seqram_pkg.sv
package seqram_pkg;

    localparam int SEQ_VAL_W   = 8;
    localparam int SEQ_IDX_W   = 8;
    localparam int SRAM_ADDR_W = 18;
    localparam int SRAM_WORD_W = 16;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_WSETUP,
        CS_WPULSE,
        CS_WHOLD,
        CS_RWAIT
    } ctrl_state_t;

    typedef struct packed {
        logic                 wr;
        logic [SEQ_IDX_W-1:0] idx;
        logic [SEQ_VAL_W-1:0] val;
    } mem_req_t;

    function automatic logic [SEQ_IDX_W-1:0] next_index(
        input logic [SEQ_IDX_W-1:0] idx,
        input logic [SEQ_IDX_W-1:0] len
    );
        return (idx == len - 1'b1) ? '0 : idx + 1'b1;
    endfunction

    function automatic logic [SRAM_WORD_W-1:0] to_word(input logic [SEQ_VAL_W-1:0] v);
        return {{(SRAM_WORD_W-SEQ_VAL_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/seqram_sram_ctrl.sv
module seqram_sram_ctrl
    import seqram_pkg::*;
#(
    parameter int WE_CYC  = 2,
    parameter int RD_WAIT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  mem_req_t               req,
    output logic                   busy,
    output logic                   rd_done,
    output logic [SEQ_VAL_W-1:0]   rd_val,
    output logic [SRAM_ADDR_W-1:0] sram_addr,
    output logic [SRAM_WORD_W-1:0] sram_wdata,
    output logic                   sram_dq_oe,
    input  logic [SRAM_WORD_W-1:0] sram_rdata,
    output logic                   sram_ce_n,
    output logic                   sram_oe_n,
    output logic                   sram_we_n
);

    localparam int MAXC  = (WE_CYC > RD_WAIT) ? WE_CYC : RD_WAIT;
    localparam int CNT_W = $clog2(MAXC + 1);

    ctrl_state_t          state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [SEQ_IDX_W-1:0] addr_q;
    logic [SEQ_VAL_W-1:0] data_q;
    logic                 unused_hi;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                CS_IDLE: if (req_valid) begin
                    addr_q  <= req.idx;
                    data_q  <= req.val;
                    cnt_q   <= '0;
                    state_q <= req.wr ? CS_WSETUP : CS_RWAIT;
                end
                CS_WSETUP: state_q <= CS_WPULSE;
                CS_WPULSE: begin
                    if (cnt_q == CNT_W'(WE_CYC - 1)) state_q <= CS_WHOLD;
                    else                             cnt_q   <= cnt_q + 1'b1;
                end
                CS_WHOLD: state_q <= CS_IDLE;
                CS_RWAIT: begin
                    if (cnt_q == CNT_W'(RD_WAIT - 1)) state_q <= CS_IDLE;
                    else                              cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != CS_IDLE);
    assign rd_done    = (state_q == CS_RWAIT) && (cnt_q == CNT_W'(RD_WAIT - 1));
    assign rd_val     = sram_rdata[SEQ_VAL_W-1:0];
    assign unused_hi  = ^sram_rdata[SRAM_WORD_W-1:SEQ_VAL_W];
    assign sram_addr  = {{(SRAM_ADDR_W-SEQ_IDX_W){1'b0}}, addr_q};
    assign sram_wdata = to_word(data_q);
    assign sram_dq_oe = (state_q == CS_WSETUP) || (state_q == CS_WPULSE) || (state_q == CS_WHOLD);
    assign sram_ce_n  = (state_q == CS_IDLE);
    assign sram_we_n  = (state_q != CS_WPULSE);
    assign sram_oe_n  = (state_q != CS_RWAIT);

endmodule

// File: rtl/seqram_seq_ctrl.sv
module seqram_seq_ctrl
    import seqram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_mode,
    input  logic                 entry_valid,
    input  logic [SEQ_VAL_W-1:0] entry_byte,
    input  logic                 run_go,
    input  logic                 tick,
    input  logic                 busy,
    input  logic                 rd_done,
    input  logic [SEQ_VAL_W-1:0] rd_val,
    output logic                 req_valid,
    output mem_req_t             req,
    output logic [SEQ_VAL_W-1:0] count_out,
    output logic [SEQ_IDX_W-1:0] seq_len
);

    localparam logic [SEQ_IDX_W-1:0] MAX_LEN = '1;

    logic [SEQ_IDX_W-1:0] len_q, idx_q, nxt;
    logic [SEQ_VAL_W-1:0] count_q;
    logic                 started_q;
    logic                 take_entry, take_go, take_tick, empty;

    assign empty      = (len_q == '0);
    assign nxt        = next_index(idx_q, len_q);
    assign take_entry = prog_mode && entry_valid && !busy && (len_q != MAX_LEN);
    assign take_go    = !prog_mode && run_go && !busy;
    assign take_tick  = !prog_mode && tick && !run_go && !busy && started_q && !empty;

    always_comb begin
        req_valid = take_entry || (take_go && !empty) || take_tick;
        req.wr    = take_entry;
        req.val   = entry_byte;
        if (take_entry)   req.idx = len_q;
        else if (take_go) req.idx = '0;
        else              req.idx = nxt;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            len_q     <= '0;
            idx_q     <= '0;
            count_q   <= '0;
            started_q <= 1'b0;
        end else begin
            if (prog_mode) started_q <= 1'b0;
            if (take_entry) len_q <= len_q + 1'b1;
            if (take_go) begin
                started_q <= 1'b1;
                idx_q     <= '0;
                if (empty) count_q <= '0;
            end
            if (take_tick) idx_q <= nxt;
            if (rd_done) count_q <= rd_val;
        end
    end

    assign count_out = count_q;
    assign seq_len   = len_q;

endmodule

// File: rtl/seqram_counter.sv
module seqram_counter
    import seqram_pkg::*;
#(
    parameter int WE_CYC  = 2,
    parameter int RD_WAIT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   prog_mode,
    input  logic                   entry_valid,
    input  logic [SEQ_VAL_W-1:0]   entry_byte,
    input  logic                   run_go,
    input  logic                   tick,
    output logic [SEQ_VAL_W-1:0]   count_out,
    output logic                   busy,
    output logic [SRAM_ADDR_W-1:0] sram_addr,
    output logic [SRAM_WORD_W-1:0] sram_wdata,
    output logic                   sram_dq_oe,
    input  logic [SRAM_WORD_W-1:0] sram_rdata,
    output logic                   sram_ce_n,
    output logic                   sram_oe_n,
    output logic                   sram_we_n
);

    logic                 req_valid, rd_done;
    mem_req_t             req_w;
    logic [SEQ_VAL_W-1:0] rd_val;
    logic [SEQ_IDX_W-1:0] seq_len;

    seqram_seq_ctrl u_seq (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .entry_valid(entry_valid),
        .entry_byte(entry_byte), .run_go(run_go), .tick(tick), .busy(busy),
        .rd_done(rd_done), .rd_val(rd_val), .req_valid(req_valid), .req(req_w),
        .count_out(count_out), .seq_len(seq_len)
    );

    seqram_sram_ctrl #(.WE_CYC(WE_CYC), .RD_WAIT(RD_WAIT)) u_mem (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req(req_w), .busy(busy),
        .rd_done(rd_done), .rd_val(rd_val), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_dq_oe(sram_dq_oe), .sram_rdata(sram_rdata),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

endmodule

// File: rtl/seqram_counter_chk.sv
module seqram_counter_chk
    import seqram_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [SRAM_ADDR_W-1:0] sram_addr,
    input logic [SRAM_WORD_W-1:0] sram_wdata,
    input logic                   sram_dq_oe,
    input logic                   sram_ce_n,
    input logic                   sram_oe_n,
    input logic                   sram_we_n,
    input logic [SEQ_VAL_W-1:0]   count_out,
    input logic [SEQ_IDX_W-1:0]   seq_len
);

    logic [7:0] we_low_cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                            we_low_cnt <= '0;
        else if (!sram_we_n && we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 1'b1;
        else if (sram_we_n)                 we_low_cnt <= '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (count_out == '0 && seq_len == '0 && sram_ce_n && sram_oe_n && sram_we_n));

    // R2
    len_step_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(seq_len) || (seq_len == $past(seq_len) + 1'b1));

    // R3
    addr_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> (sram_addr[SRAM_ADDR_W-1:SEQ_IDX_W] == '0));

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_low_cnt >= 8'd2));

    // R4
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |=> ($stable(sram_wdata) && sram_dq_oe && !sram_ce_n));

    // R4
    no_oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    // R5
    read_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_dq_oe && !sram_ce_n && sram_we_n));

    // R8
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_len == '0) |-> (count_out == '0));

endmodule

bind seqram_counter seqram_counter_chk u_chk (
    .clk(clk), .rst(rst), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .count_out(count_out), .seq_len(seq_len)
);

// File: tb/seqram_counter_tb.sv
module seqram_counter_tb;

    localparam int WE_CYC  = 2;
    localparam int RD_WAIT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_mode = 1'b0, entry_valid = 1'b0, run_go = 1'b0, tick = 1'b0;
    logic [7:0]  entry_byte = '0;
    logic [7:0]  count_out;
    logic        busy, sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;
    logic [17:0] sram_addr;
    logic [15:0] sram_wdata, sram_rdata;

    int checks = 0, fails = 0;
    int m_checks = 0, m_fails = 0, wr_count = 0, we_cnt = 0;
    int cyc = 0;
    logic [7:0] mem [0:255];
    logic [7:0] expv [0:255];

    always #5 clk = ~clk;

    seqram_counter #(.WE_CYC(WE_CYC), .RD_WAIT(RD_WAIT)) u_dut (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .entry_valid(entry_valid),
        .entry_byte(entry_byte), .run_go(run_go), .tick(tick), .count_out(count_out),
        .busy(busy), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_dq_oe(sram_dq_oe), .sram_rdata(sram_rdata), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    // SRAM model: upper byte returned is the inverse of the low byte
    always_comb begin
        if (!sram_ce_n && !sram_oe_n) sram_rdata = {~mem[sram_addr[7:0]], mem[sram_addr[7:0]]};
        else                          sram_rdata = 16'h5A5A;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if ((!sram_oe_n && !sram_we_n) || (!sram_oe_n && sram_dq_oe)) begin
                m_fails++;
                $display("FAIL R5 read/write overlap: oe_n=%0d we_n=%0d dq_oe=%0d expected no overlap",
                         sram_oe_n, sram_we_n, sram_dq_oe);
            end
            if (!sram_we_n) we_cnt++;
            else if (we_cnt != 0) begin
                m_checks++;
                if (we_cnt < WE_CYC || !sram_dq_oe || sram_ce_n || sram_wdata[15:8] != 8'h00
                    || sram_addr[17:8] != 10'd0) begin
                    m_fails++;
                    $display("FAIL R4 write cycle: low=%0d dq_oe=%0d hi=%0h addr=%0h expected low>=%0d dq_oe=1 hi=0",
                             we_cnt, sram_dq_oe, sram_wdata[15:8], sram_addr, WE_CYC);
                end
                mem[sram_addr[7:0]] = sram_wdata[7:0];
                wr_count++;
                we_cnt = 0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            $display("FAIL watchdog expired: cycles=%0d expected completion", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + m_checks + 1, fails + m_fails + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); entry_valid = 1'b1; entry_byte = b;
        @(negedge clk); entry_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic go();
        @(negedge clk); run_go = 1'b1;
        @(negedge clk); run_go = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic step();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wait_idle();
    endtask

    function automatic logic [7:0] f(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    initial begin
        int w0;
        for (int i = 0; i < 256; i++) mem[i] = 8'hC3;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(count_out == 8'h00 && sram_ce_n && sram_oe_n && sram_we_n, "R1 reset state",
            {count_out, sram_ce_n, sram_oe_n, sram_we_n}, 8'h00 << 3 | 7);
        rst = 1'b0;
        wait_idle();

        // R8 empty list
        go(); step(); step();
        chk(count_out == 8'h00, "R8 empty list output", count_out, 0);

        // R10 entry in run mode ignored
        w0 = wr_count;
        put(8'h77);
        chk(wr_count == w0, "R10 entry in run mode writes", wr_count, w0);
        go(); step();
        chk(count_out == 8'h00, "R10 entry in run mode length", count_out, 0);

        // R2 program three values
        prog_mode = 1'b1;
        for (int i = 0; i < 3; i++) put(f(i, 1));
        chk(wr_count == w0 + 3, "R2 write count", wr_count, w0 + 3);
        for (int i = 0; i < 3; i++)
            chk(mem[i] == f(i, 1), "R2 stored value", mem[i], f(i, 1));
        step();
        chk(count_out == 8'h00, "R10 tick in program mode", count_out, 0);
        prog_mode = 1'b0;
        step();
        chk(count_out == 8'h00, "R10 tick before run command", count_out, 0);

        // R6 / R7 replay with wrap
        go();
        chk(count_out == f(0, 1), "R6 run loads entry 0", count_out, f(0, 1));
        for (int k = 1; k <= 7; k++) begin
            step();
            chk(count_out == f(k % 3, 1), "R7 step/wrap len3", count_out, f(k % 3, 1));
        end

        // R11 append two more
        prog_mode = 1'b1;
        put(f(3, 1)); put(f(4, 1));
        prog_mode = 1'b0;
        w0 = count_out;
        step();
        chk(count_out == w0[7:0], "R11 tick ignored until run", count_out, w0);
        go();
        chk(count_out == f(0, 1), "R11 restart entry 0", count_out, f(0, 1));
        for (int k = 1; k <= 6; k++) begin
            step();
            chk(count_out == f(k % 5, 1), "R11 appended list len5", count_out, f(k % 5, 1));
        end

        // R1 asynchronous reset mid-run
        @(negedge clk); #2 rst = 1'b1; #1;
        chk(count_out == 8'h00, "R1 async reset clears output", count_out, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        go(); step(); step();
        chk(count_out == 8'h00, "R1 reset erased list", count_out, 0);

        // R9 full capacity sweep
        do_reset();
        prog_mode = 1'b1;
        for (int i = 0; i < 255; i++) put(f(i, 2));
        w0 = wr_count;
        put(8'hEE); put(8'hEF);
        chk(wr_count == w0, "R9 entries past capacity", wr_count, w0);
        chk(mem[255] != 8'hEE && mem[255] != 8'hEF, "R9 word 255 untouched", mem[255], 8'hC3);
        prog_mode = 1'b0;
        for (int i = 0; i < 255; i++) expv[i] = f(i, 2);
        go();
        chk(count_out == expv[0], "R6 full list entry 0", count_out, expv[0]);
        for (int k = 1; k < 261; k++) begin
            step();
            chk(count_out == expv[k % 255], "R7 R9 full list step/wrap", count_out, expv[k % 255]);
        end

        // R5 / R7 single entry list
        do_reset();
        prog_mode = 1'b1;
        put(8'h3C);
        prog_mode = 1'b0;
        go();
        chk(count_out == 8'h3C, "R5 low byte latched", count_out, 8'h3C);
        for (int k = 0; k < 3; k++) begin
            step();
            chk(count_out == 8'h3C, "R7 single entry wrap", count_out, 8'h3C);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks + m_checks, fails + m_fails);
        $finish;
    end

endmodule